// File: doc/BRIEF.md
# Indirect Memory Host Register Port

This block is a byte-wide register file through which a host reaches a large adapter RAM and steers up to four adapter channels. The host never addresses the RAM directly. It loads a 24-bit pointer as three byte registers and then moves data through one of two data windows. The first window leaves the pointer where it is. The second advances the pointer by one after each access, so a block of bytes streams through repeated accesses at a single offset.

Each channel has a control byte. Through it the host holds the channel in reset or halt, raises an interrupt toward the adapter, acknowledges an interrupt from the adapter, enables that interrupt and picks the line it drives. The four channel control bytes share one offset. A separate adapter control register chooses which channel the shared offset reaches, and it also shows the interrupt-pending state of all channels at once.

The register bus is synchronous. Reads return data one cycle after the request. The memory side is a single-port strobe interface to a synchronous RAM that answers one cycle after a read strobe.

Top module: `memwin_host_port`

## Requirements
- R1: Offset 0 reads 0xA4 when NCH is 4 and 0xA1 when NCH is 1. Writes to offsets 0 and 7 change nothing, and offset 7 reads 0x00.
- R2: Offsets 2, 3 and 4 read and write pointer bits 7:0, 15:8 and 23:16. The pointer resets to 0.
- R3: For every offset, reg_rdata carries the read result in the clock cycle after the one in which reg_rd is high.
- R4: An access at offset 5 reads or writes the memory byte at the pointer and leaves the pointer unchanged.
- R5: An access at offset 6 reads or writes the memory byte at the pointer and then adds one to the pointer. The carry runs across all 24 bits, so 0x0000FF becomes 0x000100 and 0xFFFFFF becomes 0x000000.
- R6: When the pointer is 0x40000 or above, a data access raises no memory strobe, a read returns 0x00 and a write is dropped. An access at offset 6 still advances the pointer.
- R7: Channel control bit 7 (reset) and bit 4 (halt) are read/write and drive chan_reset and chan_halt. After reset, bit 7 is 1 and every other control bit is 0.
- R8: Control bit 6 reads 1 while an adapter-to-host interrupt is pending. A pulse on adp_irq_set sets it. Writing 1 to bit 6 clears it, and writing 0 has no effect. A set in the same cycle as a clear wins.
- R9: Writing 1 to control bit 5 raises h2a_irq, and bit 5 reads 1. A pulse on adp_ack clears it. A write of 1 in the same cycle as an acknowledge wins. Writing 0 to bit 5 has no effect.
- R10: Control bit 3 enables the interrupt and bits 2:0 select the line. host_irq is high when the interrupt is pending, enabled and the line code is not 000. host_irq_line carries each channel's three-bit line code.
- R11: Bits 1:0 of the adapter control register at offset 8 select the channel that offset 1 reads and writes. The other channels are untouched.
- R12: Adapter control bits 7:4 show the pending flags of channels 3 down to 0, with bit 4+i for channel i. These bits are read-only. Bits 3:2 read 0, and writes to bits 7:2 are ignored.
- R13: mem_addr equals pointer bits 17:0. mem_wr and mem_wdata accompany a write in the same cycle. mem_rd accompanies a read in the same cycle. A simultaneous reg_rd and reg_wr acts as a write only, and at most one strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_rd | input | 1 | Register read request |
| reg_wr | input | 1 | Register write request |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| mem_addr | output | 18 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_rd |
| adp_irq_set | input | NCH | Adapter raises its interrupt to the host, one bit per channel |
| adp_ack | input | NCH | Adapter acknowledges the host interrupt, one bit per channel |
| chan_reset | output | NCH | Channel held in reset |
| chan_halt | output | NCH | Channel held in halt |
| h2a_irq | output | NCH | Host-to-adapter interrupt pending |
| host_irq | output | NCH | Enabled adapter-to-host interrupt |
| host_irq_line | output | 3*NCH | Line code per channel, channel i in bits 3i+2:3i |

## Verification
Writes take effect at the clock edge that accepts them. The control outputs, the pointer and the pending flags all change in the cycle after that edge. The memory strobes are combinational and are due in the same cycle as the request. Read data is due exactly one cycle after the request, and for the data windows it comes through from the RAM's registered output. The bench drives every input on a falling edge and samples at the next falling edge, so each value is read in the first cycle it is due. Same-cycle collisions of set with clear and of raise with acknowledge are driven on one falling edge, which puts both events into the same accepting edge.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

    typedef enum logic [3:0] {
        OFS_ID       = 4'd0,
        OFS_CTRL     = 4'd1,
        OFS_PLO      = 4'd2,
        OFS_PMID     = 4'd3,
        OFS_PHI      = 4'd4,
        OFS_DATA     = 4'd5,
        OFS_DATA_INC = 4'd6,
        OFS_RSVD     = 4'd7,
        OFS_ADPCTL   = 4'd8
    } reg_ofs_e;

    localparam int unsigned LINE_W  = 3;
    localparam int unsigned MAX_CH  = 4;
    localparam int unsigned SEL_W   = 2;

    // channel control byte, packed in readback bit order
    typedef struct packed {
        logic              rst;
        logic              pend;
        logic              h2a;
        logic              halt;
        logic              en;
        logic [LINE_W-1:0] line;
    } chan_ctl_t;

    typedef enum logic {
        SRC_REG = 1'b0,
        SRC_MEM = 1'b1
    } rd_src_e;

    function automatic logic [7:0] id_code(input int unsigned nch);
        return (nch == 1) ? 8'hA1 : 8'hA4;
    endfunction

endpackage

// File: rtl/memwin_ptr.sv
module memwin_ptr #(
    parameter int unsigned PTR_W = 24,
    localparam int unsigned NB   = PTR_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NB-1:0]    byte_we,
    input  logic [7:0]       wdata,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_st_t;

    ptr_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (inc) begin
            nxt_d.ptr = cur_q.ptr + 1'b1;
        end else begin
            for (int b = 0; b < int'(NB); b++) begin
                if (byte_we[b]) begin
                    nxt_d.ptr[b*8 +: 8] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ptr = cur_q.ptr;

endmodule

// File: rtl/memwin_chan.sv
module memwin_chan
    import memwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    input  logic              irq_set,
    input  logic              ack,
    output logic [7:0]        status,
    output logic              rst_o,
    output logic              halt_o,
    output logic              h2a_o,
    output logic              pend_o,
    output logic              irq_o,
    output logic [LINE_W-1:0] line_o
);

    chan_ctl_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (wr_en) begin
            nxt_d.rst  = wdata[7];
            nxt_d.halt = wdata[4];
            nxt_d.en   = wdata[3];
            nxt_d.line = wdata[LINE_W-1:0];
        end
        // raise from the host beats an acknowledge in the same cycle
        if (wr_en && wdata[5]) begin
            nxt_d.h2a = 1'b1;
        end else if (ack) begin
            nxt_d.h2a = 1'b0;
        end
        // a new adapter event beats a host clear in the same cycle
        if (irq_set) begin
            nxt_d.pend = 1'b1;
        end else if (wr_en && wdata[6]) begin
            nxt_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q     <= '0;
            cur_q.rst <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign status = cur_q;
    assign rst_o  = cur_q.rst;
    assign halt_o = cur_q.halt;
    assign h2a_o  = cur_q.h2a;
    assign pend_o = cur_q.pend;
    assign line_o = cur_q.line;
    assign irq_o  = cur_q.pend && cur_q.en && (cur_q.line != '0);

endmodule

// File: rtl/memwin_host_port.sv
module memwin_host_port
    import memwin_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned PTR_W  = 24,
    parameter int unsigned MEM_AW = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            reg_addr,
    input  logic                  reg_rd,
    input  logic                  reg_wr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    output logic [MEM_AW-1:0]     mem_addr,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [7:0]            mem_wdata,
    input  logic [7:0]            mem_rdata,
    input  logic [NCH-1:0]        adp_irq_set,
    input  logic [NCH-1:0]        adp_ack,
    output logic [NCH-1:0]        chan_reset,
    output logic [NCH-1:0]        chan_halt,
    output logic [NCH-1:0]        h2a_irq,
    output logic [NCH-1:0]        host_irq,
    output logic [LINE_W*NCH-1:0] host_irq_line
);

    localparam int unsigned NB     = PTR_W / 8;
    localparam int unsigned PAD_W  = 8 - MAX_CH - SEL_W;
    localparam logic [7:0]  ID_VAL = id_code(NCH);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        rd_src_e          src;
        logic [7:0]       rbyte;
    } top_st_t;

    top_st_t cur_q, nxt_d;

    logic [PTR_W-1:0]  ptr_q;
    logic [SEL_W-1:0]  sel_q;
    logic [NB-1:0]     byte_we;
    logic              acc_mem;
    logic              acc_inc;
    logic              in_range;
    logic              ctrl_wr;
    logic [NCH-1:0]    chan_we;
    logic [NCH-1:0]    pend;
    logic [7:0]        chan_stat [NCH];
    logic [7:0]        sel_stat;
    logic [MAX_CH-1:0] mirror;

    // ---------------- decode ----------------
    assign acc_mem  = (reg_rd || reg_wr) &&
                      ((reg_addr == OFS_DATA) || (reg_addr == OFS_DATA_INC));
    assign acc_inc  = (reg_rd || reg_wr) && (reg_addr == OFS_DATA_INC);
    assign in_range = (ptr_q[PTR_W-1:MEM_AW] == '0);
    assign ctrl_wr  = reg_wr && (reg_addr == OFS_CTRL);

    generate
        for (genvar b = 0; b < int'(NB); b++) begin : g_byte_we
            assign byte_we[b] = reg_wr && (reg_addr == 4'(int'(OFS_PLO) + b));
        end
    endgenerate

    // ---------------- pointer ----------------
    memwin_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_we (byte_we),
        .wdata   (reg_wdata),
        .inc     (acc_inc),
        .ptr     (ptr_q)
    );

    // ---------------- memory port ----------------
    assign mem_addr  = ptr_q[MEM_AW-1:0];
    assign mem_wdata = reg_wdata;
    assign mem_wr    = reg_wr && acc_mem && in_range;
    assign mem_rd    = reg_rd && !reg_wr && acc_mem && in_range;

    // ---------------- channel bank ----------------
    generate
        for (genvar i = 0; i < int'(NCH); i++) begin : g_chan
            assign chan_we[i] = ctrl_wr && (sel_q == SEL_W'(i));
            memwin_chan u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (chan_we[i]),
                .wdata   (reg_wdata),
                .irq_set (adp_irq_set[i]),
                .ack     (adp_ack[i]),
                .status  (chan_stat[i]),
                .rst_o   (chan_reset[i]),
                .halt_o  (chan_halt[i]),
                .h2a_o   (h2a_irq[i]),
                .pend_o  (pend[i]),
                .irq_o   (host_irq[i]),
                .line_o  (host_irq_line[i*LINE_W +: LINE_W])
            );
        end
        for (genvar i = 0; i < int'(MAX_CH); i++) begin : g_mirror
            if (i < int'(NCH)) begin : g_live
                assign mirror[i] = pend[i];
            end else begin : g_absent
                assign mirror[i] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        sel_stat = '0;
        for (int i = 0; i < int'(NCH); i++) begin
            if (sel_q == SEL_W'(i)) begin
                sel_stat = chan_stat[i];
            end
        end
    end

    // ---------------- register state ----------------
    assign sel_q = cur_q.sel;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.src = SRC_REG;
        if (reg_wr && (reg_addr == OFS_ADPCTL)) begin
            nxt_d.sel = reg_wdata[SEL_W-1:0];
        end
        if (reg_rd) begin
            nxt_d.rbyte = 8'h00;
            case (reg_addr)
                OFS_ID:     nxt_d.rbyte = ID_VAL;
                OFS_CTRL:   nxt_d.rbyte = sel_stat;
                OFS_PLO:    nxt_d.rbyte = ptr_q[7:0];
                OFS_PMID:   nxt_d.rbyte = ptr_q[15:8];
                OFS_PHI:    nxt_d.rbyte = ptr_q[23:16];
                OFS_DATA,
                OFS_DATA_INC: begin
                    if (!reg_wr && in_range) begin
                        nxt_d.src = SRC_MEM;
                    end
                end
                OFS_ADPCTL: nxt_d.rbyte = {mirror, {PAD_W{1'b0}}, sel_q};
                default:    nxt_d.rbyte = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{sel: '0, src: SRC_REG, rbyte: 8'h00};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign reg_rdata = (cur_q.src == SRC_MEM) ? mem_rdata : cur_q.rbyte;

endmodule

// File: rtl/memwin_host_port_chk.sv
module memwin_host_port_chk #(
    parameter int unsigned NCH   = 4,
    parameter int unsigned PTR_W = 24,
    parameter int unsigned MEM_AW = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       reg_addr,
    input logic             reg_rd,
    input logic             reg_wr,
    input logic [7:0]       reg_wdata,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic [PTR_W-1:0] ptr,
    input logic [1:0]       chan_sel,
    input logic [NCH-1:0]   adp_ack,
    input logic [NCH-1:0]   h2a_irq,
    input logic [NCH-1:0]   chan_reset
);

    logic acc, ctl0_wr;
    assign acc     = reg_rd || reg_wr;
    assign ctl0_wr = reg_wr && (reg_addr == 4'd1) && (chan_sel == 2'd0);

    // R4: the plain data window leaves the pointer alone
    a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && reg_addr == 4'd5) |=> $stable(ptr));

    // R5: the incrementing window adds one with full carry
    a_r5_ptr_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && reg_addr == 4'd6) |=> (ptr == $past(ptr) + 1'b1));

    // R6: no strobe when the pointer is beyond the RAM
    a_r6_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (reg_addr == 4'd5 || reg_addr == 4'd6) && ptr[PTR_W-1:MEM_AW] != '0)
        |-> (!mem_rd && !mem_wr));

    // R13: at most one memory strobe at a time
    a_r13_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));

    // R7: reset bit written through channel 0 reaches its output
    a_r7_reset_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ctl0_wr |=> (chan_reset[0] == $past(reg_wdata[7])));

    // R9: an acknowledge without a same-cycle raise drops the request
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (adp_ack[0] && !(ctl0_wr && reg_wdata[5])) |=> !h2a_irq[0]);

endmodule

bind memwin_host_port memwin_host_port_chk #(
    .NCH(NCH), .PTR_W(PTR_W), .MEM_AW(MEM_AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .ptr        (ptr_q),
    .chan_sel   (sel_q),
    .adp_ack    (adp_ack),
    .h2a_irq    (h2a_irq),
    .chan_reset (chan_reset)
);

// File: tb/memwin_host_port_bench.sv
module memwin_host_port_bench;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [17:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [NCH-1:0] adp_irq_set = '0, adp_ack = '0;
    logic [NCH-1:0] chan_reset, chan_halt, h2a_irq, host_irq;
    logic [3*NCH-1:0] host_irq_line;

    int n_chk = 0, n_fail = 0;
    int n_mrd = 0, n_mwr = 0;
    logic [7:0] bmem [0:1023];

    always #2 clk = ~clk;

    memwin_host_port #(.NCH(NCH)) u_memwin_host_port (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .adp_irq_set(adp_irq_set), .adp_ack(adp_ack),
        .chan_reset(chan_reset), .chan_halt(chan_halt), .h2a_irq(h2a_irq),
        .host_irq(host_irq), .host_irq_line(host_irq_line)
    );

    // synchronous RAM model, aliased onto 1 KiB
    always @(posedge clk) begin
        if (mem_wr) begin
            bmem[mem_addr[9:0]] <= mem_wdata;
            n_mwr <= n_mwr + 1;
        end
        if (mem_rd) begin
            mem_rdata <= bmem[mem_addr[9:0]];
            n_mrd <= n_mrd + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic set_ptr(input logic [23:0] p);
        bus_wr(4'd2, p[7:0]);
        bus_wr(4'd3, p[15:8]);
        bus_wr(4'd4, p[23:16]);
    endtask

    task automatic get_ptr(output logic [23:0] p);
        logic [7:0] b0, b1, b2;
        bus_rd(4'd2, b0);
        bus_rd(4'd3, b1);
        bus_rd(4'd4, b2);
        p = {b2, b1, b0};
    endtask

    task automatic pulse_set(input logic [NCH-1:0] m);
        @(negedge clk); adp_irq_set = m;
        @(negedge clk); adp_irq_set = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        logic [23:0] p;
        bus_rd(4'd0, d);      chk("R1 id after reset", d, 8'hA4);
        bus_rd(4'd1, d);      chk("R7 ctrl reset value", d, 8'h80);
        chk("R7 chan_reset after reset", chan_reset, 4'hF);
        bus_rd(4'd8, d);      chk("R12 adapter ctrl reset", d, 8'h00);
        get_ptr(p);           chk("R2 pointer reset", p, 24'h0);
        chk("R10 host_irq idle", host_irq, 4'h0);
    endtask

    task automatic t_pointer();
        logic [23:0] p;
        set_ptr(24'hC3_5A_12);
        get_ptr(p);           chk("R2 pointer bytes readback", p, 24'hC35A12);
    endtask

    task automatic t_hold();
        logic [7:0] d;
        logic [23:0] p;
        set_ptr(24'h000010);
        @(negedge clk);
        reg_addr = 4'd5; reg_wdata = 8'h5A; reg_wr = 1'b1;
        #0.5;
        chk("R13 mem_wr in write cycle", {mem_wr, mem_rd}, 2'b10);
        chk("R13 mem_addr", mem_addr, 18'h10);
        @(negedge clk); reg_wr = 1'b0;
        chk("R13 memory holds written byte", bmem[10'h10], 8'h5A);
        bus_rd(4'd5, d);      chk("R4 R3 data window read", d, 8'h5A);
        get_ptr(p);           chk("R4 pointer unchanged", p, 24'h000010);
    endtask

    task automatic t_inc();
        logic [7:0] d;
        logic [23:0] p;
        set_ptr(24'h0000FE);
        bus_wr(4'd6, 8'h11);
        bus_wr(4'd6, 8'h22);
        bus_wr(4'd6, 8'h33);
        get_ptr(p);           chk("R5 carry into mid byte", p, 24'h000101);
        set_ptr(24'h0000FE);
        bus_rd(4'd6, d);      chk("R5 stream byte 0", d, 8'h11);
        bus_rd(4'd6, d);      chk("R5 stream byte 1", d, 8'h22);
        bus_rd(4'd6, d);      chk("R5 stream byte 2", d, 8'h33);
    endtask

    task automatic t_range();
        logic [7:0] d;
        logic [23:0] p;
        int wr0, rd0;
        set_ptr(24'h03FFFF);
        bus_wr(4'd6, 8'h44);
        get_ptr(p);           chk("R5 carry into high byte", p, 24'h040000);
        wr0 = n_mwr; rd0 = n_mrd;
        bus_wr(4'd5, 8'h77);
        chk("R6 write beyond RAM dropped", n_mwr, wr0);
        bus_rd(4'd5, d);      chk("R6 read beyond RAM is zero", d, 8'h00);
        chk("R6 no read strobe beyond RAM", n_mrd, rd0);
        set_ptr(24'hFFFFFF);
        bus_rd(4'd6, d);      chk("R6 read at top is zero", d, 8'h00);
        get_ptr(p);           chk("R5 R6 pointer wraps to zero", p, 24'h000000);
    endtask

    task automatic t_ctrl();
        logic [7:0] d;
        bus_wr(4'd1, 8'h00);
        chk("R7 reset released", chan_reset[0], 1'b0);
        bus_wr(4'd1, 8'h90);
        chk("R7 reset and halt set", {chan_reset[0], chan_halt[0]}, 2'b11);
        bus_rd(4'd1, d);      chk("R7 ctrl readback", d, 8'h90);
        bus_wr(4'd1, 8'h0B);
        bus_rd(4'd1, d);      chk("R10 enable and line readback", d, 8'h0B);
        chk("R10 line output", host_irq_line[2:0], 3'd3);
        chk("R7 halt released", chan_halt[0], 1'b0);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        pulse_set(4'b0001);
        chk("R10 host_irq raised", host_irq[0], 1'b1);
        bus_rd(4'd1, d);      chk("R8 pending reads 1", d, 8'h4B);
        bus_rd(4'd8, d);      chk("R12 mirror of channel 0", d, 8'h10);
        bus_wr(4'd1, 8'h0B);
        bus_rd(4'd1, d);      chk("R8 write 0 keeps pending", d, 8'h4B);
        bus_wr(4'd1, 8'h4B);
        bus_rd(4'd1, d);      chk("R8 write 1 clears", d, 8'h0B);
        chk("R10 host_irq dropped", host_irq[0], 1'b0);
        pulse_set(4'b0001);
        @(negedge clk);
        reg_addr = 4'd1; reg_wdata = 8'h4B; reg_wr = 1'b1; adp_irq_set = 4'b0001;
        @(negedge clk);
        reg_wr = 1'b0; adp_irq_set = '0;
        bus_rd(4'd1, d);      chk("R8 set beats clear", d, 8'h4B);
        bus_wr(4'd1, 8'h4B);
    endtask

    task automatic t_h2a();
        logic [7:0] d;
        bus_wr(4'd1, 8'h2B);
        chk("R9 h2a raised", h2a_irq[0], 1'b1);
        bus_rd(4'd1, d);      chk("R9 bit 5 reads 1", d, 8'h2B);
        bus_wr(4'd1, 8'h0B);
        chk("R9 write 0 keeps request", h2a_irq[0], 1'b1);
        @(negedge clk); adp_ack = 4'b0001;
        @(negedge clk); adp_ack = '0;
        bus_rd(4'd1, d);      chk("R9 ack clears bit 5", d, 8'h0B);
        @(negedge clk);
        reg_addr = 4'd1; reg_wdata = 8'h2B; reg_wr = 1'b1; adp_ack = 4'b0001;
        @(negedge clk);
        reg_wr = 1'b0; adp_ack = '0;
        chk("R9 raise beats ack", h2a_irq[0], 1'b1);
        @(negedge clk); adp_ack = 4'b0001;
        @(negedge clk); adp_ack = '0;
    endtask

    task automatic t_bank();
        logic [7:0] d;
        bus_wr(4'd8, 8'h01);
        bus_wr(4'd1, 8'h08);
        pulse_set(4'b0010);
        chk("R10 line 000 keeps host_irq low", host_irq[1], 1'b0);
        bus_rd(4'd1, d);      chk("R11 channel 1 ctrl", d, 8'h48);
        bus_wr(4'd1, 8'h48);
        bus_wr(4'd8, 8'h02);
        bus_wr(4'd1, 8'h0C);
        chk("R11 only selected channels touched", chan_reset, 4'b1000);
        chk("R10 channel 2 line", host_irq_line[8:6], 3'd4);
        bus_rd(4'd1, d);      chk("R11 channel 2 ctrl", d, 8'h0C);
        bus_wr(4'd8, 8'h00);
        bus_rd(4'd1, d);      chk("R11 channel 0 kept", d, 8'h0B);
    endtask

    task automatic t_mirror();
        logic [7:0] d;
        pulse_set(4'b1010);
        bus_wr(4'd8, 8'hFC);
        bus_rd(4'd8, d);      chk("R12 mirror read-only, pad zero", d, 8'hA0);
        bus_wr(4'd8, 8'h03);
        bus_wr(4'd1, 8'hC0);
        bus_rd(4'd8, d);      chk("R12 clear via channel ctrl", d, 8'h23);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        bus_wr(4'd7, 8'h55);
        bus_wr(4'd0, 8'h00);
        bus_rd(4'd7, d);      chk("R1 reserved reads zero", d, 8'h00);
        bus_rd(4'd0, d);      chk("R1 id unaffected by write", d, 8'hA4);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) bmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pointer();
        t_hold();
        t_inc();
        t_range();
        t_ctrl();
        t_irq();
        t_h2a();
        t_bank();
        t_mirror();
        t_reserved();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule